// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block is the decision core of an eight-line interrupt controller. It is purely combinational. Each evaluation takes the request, mask and in-service vectors held by the surrounding controller, together with a rotation offset and three mode flags. From these it decides whether the controller's interrupt output should be asserted and which line is the winner.

Priority is circular. The offset names the line that currently ranks highest, and the ranking continues upward from that line modulo the line count. A pending request raises an interrupt only when it ranks strictly above the best line that is currently being serviced.

The block also has a second, independent search. It finds the highest-ranked in-service line within a caller-supplied selection vector. The controller uses this result to decide which line a non-specific end-of-interrupt command retires.

Register storage, bus decoding and the acknowledge sequence all stay in the enclosing controller. The outputs settle within the controller's clock period.

Top module: `prio_res_top`

## Requirements
- R1: A request bit participates only when its mask bit is 0. A request whose mask bit is 1 never sets `irq_valid` and is never reported on `irq_line`.
- R2: Rank is circular. With `rot_ofs` = k, line k ranks highest, followed by line k+1 and so on, with line (k+7) mod 8 lowest. With k = 0, line 0 is highest and line 7 lowest.
- R3: When `irq_valid` is 1, `irq_line` is the highest-ranked participating request line.
- R4: `irq_valid` is 1 only when the best pending rank number is strictly smaller than `cur_prio`. An equal rank does not raise an interrupt.
- R5: `cur_prio` is the rank number, from 0 (highest) to 7 (lowest), of the highest-ranked counted in-service bit. It is 8 when no in-service bit counts.
- R6: When `nest_en`=1, `is_master`=1, and the winning request is line 2, in-service bit 2 is not counted for `cur_prio`.
- R7: The exclusion of R6 does not apply when `is_master`=0, or when the winning request is a line other than 2.
- R8: When `smask_en`=1, in-service bits whose mask bit is 1 are not counted for `cur_prio`. When `smask_en`=0, all in-service bits count.
- R9: `isr_top_valid` is 1 exactly when `isr_vec & eoi_sel` is non-zero. `isr_top_line` is then the highest-ranked line in that vector under the rank order of R2.
- R10: When `irq_valid` is 0, `irq_line` is 0. When `isr_top_valid` is 0, `isr_top_line` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_vec | input | 8 | Request bits, one per line |
| mask_vec | input | 8 | Mask bits, 1 blocks the line |
| isr_vec | input | 8 | In-service bits |
| rot_ofs | input | 3 | Line that currently ranks highest |
| nest_en | input | 1 | Nested cascade mode: ignore in-service bit 2 when line 2 wins |
| smask_en | input | 1 | Masked in-service bits do not block lower ranks |
| is_master | input | 1 | This controller is the head of the cascade |
| eoi_sel | input | 8 | Selects in-service bits for the end-of-interrupt search |
| irq_valid | output | 1 | An interrupt should be raised |
| irq_line | output | 3 | Winning request line |
| cur_prio | output | 4 | Rank of the counted in-service level, 8 if none |
| isr_top_valid | output | 1 | End-of-interrupt search found a line |
| isr_top_line | output | 3 | Highest-ranked selected in-service line |

## Verification
The block holds no state, so an internal error shows up at the ports within the same evaluation. Three kinds of fault are visible in different ways:
- A wrong rotation index moves `irq_line` or `isr_top_line` to a neighbour of the expected line.
- A wrong exclusion term in the in-service path changes `cur_prio`, and with it flips `irq_valid`.
- An off-by-one in the comparison shows up only when the pending rank and the in-service rank are equal.

The bench therefore pairs directed cases for each of these situations with a sweep over every offset and every mode combination.

// File: rtl/prio_res_pkg.sv
package prio_res_pkg;
  // Default number of interrupt lines handled by one resolver (power of two).
  localparam int unsigned LINES_DEF   = 8;
  // Line that carries the downstream controller in a cascade.
  localparam int unsigned CASCADE_DEF = 2;
endpackage

// File: rtl/prio_rotator.sv
// Circular right rotation: bit i of the result is bit (i + ofs) mod N of the input.
module prio_rotator #(
  parameter int unsigned N     = 8,
  parameter int unsigned OFS_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [N-1:0]     rot_o
);
  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic [OFS_W-1:0] src;
      src      = OFS_W'(i) + ofs_i;
      rot_o[i] = vec_i[src];
    end
  end
endmodule

// File: rtl/prio_lsb_finder.sv
// Index of the lowest set bit; returns N when the vector is empty.
module prio_lsb_finder #(
  parameter int unsigned N      = 8,
  parameter int unsigned PRIO_W = $clog2(N) + 1
) (
  input  logic [N-1:0]      vec_i,
  output logic [PRIO_W-1:0] prio_o
);
  always_comb begin
    prio_o = PRIO_W'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) prio_o = PRIO_W'(i);
    end
  end
endmodule

// File: rtl/prio_rank_enc.sv
// Rank of the best bit in a vector under circular priority starting at ofs.
module prio_rank_enc #(
  parameter int unsigned N      = 8,
  parameter int unsigned OFS_W  = $clog2(N),
  parameter int unsigned PRIO_W = OFS_W + 1
) (
  input  logic [N-1:0]      vec_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [PRIO_W-1:0] rank_o
);
  logic [N-1:0] rotated;

  prio_rotator #(.N(N), .OFS_W(OFS_W)) u_rot (
    .vec_i (vec_i),
    .ofs_i (ofs_i),
    .rot_o (rotated)
  );

  prio_lsb_finder #(.N(N), .PRIO_W(PRIO_W)) u_find (
    .vec_i  (rotated),
    .prio_o (rank_o)
  );
endmodule

// File: rtl/prio_res_top.sv
module prio_res_top #(
  parameter  int unsigned NLINES       = prio_res_pkg::LINES_DEF,
  parameter  int unsigned CASCADE_LINE = prio_res_pkg::CASCADE_DEF,
  localparam int unsigned IDX_W        = $clog2(NLINES),
  localparam int unsigned PRIO_W       = IDX_W + 1
) (
  input  logic [NLINES-1:0] req_vec,
  input  logic [NLINES-1:0] mask_vec,
  input  logic [NLINES-1:0] isr_vec,
  input  logic [IDX_W-1:0]  rot_ofs,
  input  logic              nest_en,
  input  logic              smask_en,
  input  logic              is_master,
  input  logic [NLINES-1:0] eoi_sel,
  output logic              irq_valid,
  output logic [IDX_W-1:0]  irq_line,
  output logic [PRIO_W-1:0] cur_prio,
  output logic              isr_top_valid,
  output logic [IDX_W-1:0]  isr_top_line
);
  localparam logic [PRIO_W-1:0] NONE_RANK   = PRIO_W'(NLINES);
  localparam logic [NLINES-1:0] CASCADE_BIT = NLINES'(1) << CASCADE_LINE;

  logic [NLINES-1:0] pend_vec, cur_vec, eoi_vec;
  logic [PRIO_W-1:0] pend_rank, eoi_rank;
  logic [IDX_W-1:0]  pend_line;
  logic              nest_skip;

  // Requests that are allowed to compete.
  assign pend_vec = req_vec & ~mask_vec;

  prio_rank_enc #(.N(NLINES), .OFS_W(IDX_W), .PRIO_W(PRIO_W)) u_pend (
    .vec_i  (pend_vec),
    .ofs_i  (rot_ofs),
    .rank_o (pend_rank)
  );

  assign pend_line = pend_rank[IDX_W-1:0] + rot_ofs;

  // Cascade input does not block itself in nested mode on the head controller.
  assign nest_skip = nest_en && is_master && (pend_rank != NONE_RANK)
                     && (pend_line == IDX_W'(CASCADE_LINE));

  always_comb begin
    cur_vec = isr_vec;
    if (smask_en)  cur_vec = cur_vec & ~mask_vec;
    if (nest_skip) cur_vec = cur_vec & ~CASCADE_BIT;
  end

  prio_rank_enc #(.N(NLINES), .OFS_W(IDX_W), .PRIO_W(PRIO_W)) u_cur (
    .vec_i  (cur_vec),
    .ofs_i  (rot_ofs),
    .rank_o (cur_prio)
  );

  // Strict comparison; an empty pending vector carries NONE_RANK and never wins.
  assign irq_valid = pend_rank < cur_prio;
  assign irq_line  = irq_valid ? pend_line : '0;

  assign eoi_vec = isr_vec & eoi_sel;

  prio_rank_enc #(.N(NLINES), .OFS_W(IDX_W), .PRIO_W(PRIO_W)) u_eoi (
    .vec_i  (eoi_vec),
    .ofs_i  (rot_ofs),
    .rank_o (eoi_rank)
  );

  assign isr_top_valid = eoi_rank != NONE_RANK;
  assign isr_top_line  = isr_top_valid ? (eoi_rank[IDX_W-1:0] + rot_ofs) : '0;
endmodule

// File: rtl/prio_res_chk.sv
module prio_res_chk #(
  parameter  int unsigned NLINES = 8,
  localparam int unsigned IDX_W  = $clog2(NLINES),
  localparam int unsigned PRIO_W = IDX_W + 1
) (
  input logic [NLINES-1:0] req_vec,
  input logic [NLINES-1:0] mask_vec,
  input logic [NLINES-1:0] isr_vec,
  input logic [IDX_W-1:0]  rot_ofs,
  input logic              nest_en,
  input logic              smask_en,
  input logic              is_master,
  input logic [NLINES-1:0] eoi_sel,
  input logic              irq_valid,
  input logic [IDX_W-1:0]  irq_line,
  input logic [PRIO_W-1:0] cur_prio,
  input logic              isr_top_valid,
  input logic [IDX_W-1:0]  isr_top_line
);
  always_comb begin
    // R1
    unmasked_win_chk: assert (!irq_valid || (req_vec[irq_line] && !mask_vec[irq_line]))
      else $error("winner is not an unmasked request");
    // R5
    prio_range_chk: assert (cur_prio <= PRIO_W'(NLINES))
      else $error("current priority out of range");
    // R5
    empty_isr_chk: assert ((isr_vec != '0) || (cur_prio == PRIO_W'(NLINES)))
      else $error("empty in-service vector must give sentinel rank");
    // R9
    eoi_pick_chk: assert (!isr_top_valid || (isr_vec[isr_top_line] && eoi_sel[isr_top_line]))
      else $error("end-of-interrupt pick not a selected in-service line");
    // R9
    eoi_found_chk: assert (isr_top_valid == ((isr_vec & eoi_sel) != '0))
      else $error("end-of-interrupt valid mismatch");
    // R10
    idle_line_chk: assert (irq_valid || (irq_line == '0))
      else $error("line not zero while idle");
  end
endmodule

bind prio_res_top prio_res_chk #(.NLINES(NLINES)) u_chk (.*);

// File: tb/tb_prio_res_top.sv
`timescale 1ns/1ps
module tb_prio_res_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] req_vec, mask_vec, isr_vec, eoi_sel;
  logic [2:0] rot_ofs;
  logic       nest_en, smask_en, is_master;
  logic       irq_valid, isr_top_valid;
  logic [2:0] irq_line, isr_top_line;
  logic [3:0] cur_prio;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  prio_res_top dut (.*);

  // Rank of the best line of v under circular order starting at ofs; 8 if empty.
  function automatic int rank_of(logic [7:0] v, int ofs);
    for (int p = 0; p < 8; p++) if (v[(p + ofs) % 8]) return p;
    return 8;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (req=%h mask=%h isr=%h ofs=%0d nest=%0b smask=%0b master=%0b)",
               tag, act, exp, req_vec, mask_vec, isr_vec, rot_ofs, nest_en, smask_en, is_master);
    end
  endtask

  task automatic drive(logic [7:0] r, logic [7:0] m, logic [7:0] s, int ofs,
                       bit ne, bit sm, bit ms, logic [7:0] e);
    @(posedge clk); #1;
    req_vec = r; mask_vec = m; isr_vec = s; rot_ofs = 3'(ofs);
    nest_en = ne; smask_en = sm; is_master = ms; eoi_sel = e;
    #1;
  endtask

  // Full expectation from the requirements for the currently driven inputs.
  task automatic check_model();
    int ofs, pp, pl, cp, ep, el;
    logic [7:0] cv;
    bit v;
    ofs = int'(rot_ofs);
    pp = rank_of(req_vec & ~mask_vec, ofs);      // R1, R2
    pl = (pp + ofs) % 8;
    cv = isr_vec;
    if (smask_en) cv = cv & ~mask_vec;            // R8
    if (nest_en && is_master && pp < 8 && pl == 2) cv[2] = 1'b0;  // R6, R7
    cp = rank_of(cv, ofs);
    v  = pp < cp;
    ep = rank_of(isr_vec & eoi_sel, ofs);
    el = (ep < 8) ? (ep + ofs) % 8 : 0;
    check("R4 irq_valid", int'(irq_valid), int'(v));
    check("R3 irq_line", int'(irq_line), v ? pl : 0);
    check("R5 cur_prio", int'(cur_prio), cp);
    check("R9 isr_top_valid", int'(isr_top_valid), int'(ep < 8));
    check("R9 isr_top_line", int'(isr_top_line), el);
  endtask

  initial begin
    logic [31:0] lf;
    req_vec = '0; mask_vec = '0; isr_vec = '0; eoi_sel = '0; rot_ofs = '0;
    nest_en = 0; smask_en = 0; is_master = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Quiescent inputs: R5, R10
    drive(8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 8'hFF);
    check("R10 idle valid", int'(irq_valid), 0);
    check("R10 idle line", int'(irq_line), 0);
    check("R5 idle cur_prio", int'(cur_prio), 8);
    check("R10 idle top", int'(isr_top_line), 0);
    // R1: everything masked
    drive(8'hFF, 8'hFF, 8'h00, 0, 0, 0, 1, 8'hFF);
    check("R1 all masked", int'(irq_valid), 0);
    drive(8'h81, 8'h01, 8'h00, 0, 0, 0, 1, 8'hFF);
    check("R1 masked line skipped", int'(irq_line), 7);
    // R2: offset 0 and offset 3 ordering
    drive(8'hFF, 8'h00, 8'h00, 0, 0, 0, 1, 8'h00);
    check("R2 ofs0 top line", int'(irq_line), 0);
    drive(8'hFF, 8'h00, 8'h00, 3, 0, 0, 1, 8'h00);
    check("R2 ofs3 top line", int'(irq_line), 3);
    drive(8'h06, 8'h00, 8'h00, 3, 0, 0, 1, 8'h00);
    check("R2 ofs3 line2 lowest", int'(irq_line), 1);
    // R4: equal rank blocks, higher rank passes
    drive(8'h08, 8'h00, 8'h08, 0, 0, 0, 1, 8'h00);
    check("R4 equal rank", int'(irq_valid), 0);
    drive(8'h04, 8'h00, 8'h08, 0, 0, 0, 1, 8'h00);
    check("R4 higher rank", int'(irq_valid), 1);
    check("R3 higher rank line", int'(irq_line), 2);
    // R6 / R7: nested cascade exclusion
    drive(8'h04, 8'h00, 8'h04, 0, 1, 0, 1, 8'h00);
    check("R6 cascade self", int'(irq_valid), 1);
    check("R6 cur_prio", int'(cur_prio), 8);
    drive(8'h04, 8'h00, 8'h04, 0, 1, 0, 0, 8'h00);
    check("R7 not master", int'(irq_valid), 0);
    drive(8'h08, 8'h00, 8'h08, 0, 1, 0, 1, 8'h00);
    check("R7 other line", int'(irq_valid), 0);
    // R8: special mask
    drive(8'h10, 8'h01, 8'h01, 0, 0, 0, 1, 8'h00);
    check("R8 off", int'(irq_valid), 0);
    drive(8'h10, 8'h01, 8'h01, 0, 0, 1, 1, 8'h00);
    check("R8 on", int'(irq_valid), 1);
    check("R8 on line", int'(irq_line), 4);
    // R9: end-of-interrupt search with rotation and selection
    drive(8'h00, 8'h00, 8'h30, 5, 0, 0, 1, 8'hFF);
    check("R9 top line", int'(isr_top_line), 5);
    drive(8'h00, 8'h00, 8'h30, 5, 0, 0, 1, 8'hDF);
    check("R9 selected line", int'(isr_top_line), 4);
    drive(8'h00, 8'h00, 8'h30, 5, 0, 0, 1, 8'hCF);
    check("R10 top empty", int'(isr_top_valid), 0);

    // Sweep: every offset and mode combination, pseudo-random vectors.
    lf = 32'h1234_5678;
    for (int o = 0; o < 8; o++) begin
      for (int md = 0; md < 8; md++) begin
        for (int n = 0; n < 64; n++) begin
          logic [7:0] r, m, s, e;
          lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
          r = lf[7:0]; m = lf[15:8] & lf[23:16]; s = lf[31:24] & lf[11:4];
          e = (n % 4 == 0) ? 8'hFF : lf[19:12];
          drive(r, m, s, o, md[0], md[1], md[2], e);
          check_model();
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule